// File: doc/BRIEF.md
# ADPCM Speech Encoder

This block turns a stream of 8-bit mu-law companded telephone samples into a stream of 4-bit adaptive differential codes, one code for each tick of the sample clock. At the usual 8 kHz sample rate, the 64 kb/s input becomes a 32 kb/s output, which halves the data.

For each sample, the block first expands the companded byte to a signed linear value. It then subtracts the current prediction and quantizes the difference into a sign and a 3-bit magnitude, using a step size taken from a geometric table. After that it rebuilds the signal from the new code alone, in the same way a remote decoder would, and keeps the result as the next prediction. It also moves the step index up or down according to the magnitude.

Samples are taken only while the encode enable is high. Between enabled samples, the output code and all internal state stay unchanged.

Top module: `adpcm_speech_enc`

## Requirements
- R1: The input byte b is expanded as follows. Let u = ~b, the exponent e = u[6:4] and the mantissa m = u[3:0]. Then the magnitude is ((8*m + 132) << e) - 132, and the linear value is the negative of that magnitude when u[7] = 1 and the magnitude itself otherwise. Byte 0xFF gives 0, byte 0x80 gives +32124 and byte 0x00 gives -32124.
- R2: The difference is d = linear - prediction. Code bit 3 is 1 exactly when d < 0.
- R3: The magnitude bits are set by successive tests on |d|. Bit 2 is set when |d| >= step, and step is then subtracted. Bit 1 is set when the remainder is >= step>>1, and step>>1 is then subtracted. Bit 0 is set when the remainder is >= step>>2.
- R4: The new prediction is the old prediction plus or minus (sign from bit 3) the sum of step>>3 and the following terms: step when bit 2 is set, step>>1 when bit 1 is set, and step>>2 when bit 0 is set. The result saturates to the range -32768..32767.
- R5: The step index changes by -1 for magnitudes 0 to 3, and by +2, +4, +6 or +8 for magnitudes 4, 5, 6 or 7. It saturates at 0 and 88.
- R6: The step for index k is defined by step(0) = 7 and step(k+1) = min(32767, step(k) + step(k)/10 + 1), using integer division.
- R7: The code is registered. It changes only at the clock edge that samples the enable high, and it is unchanged between a change of the input and that edge.
- R8: While the enable is low, the code, the prediction and the step index hold their values.
- R9: Reset sets the code, the prediction and the step index to zero. The first sample after reset is therefore coded against a prediction of 0 and a step of 7: byte 0xFE (linear +8) gives code 0x5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_en | input | 1 | Encode enable; a sample is taken on each rising edge while this is high |
| law_byte | input | 8 | Companded mu-law input sample |
| adpcm_code | output | 4 | Registered code: bit 3 is the sign, bits 2:0 are the magnitude |

## Verification
The bench uses the default parameters: a 16-bit prediction, a 7-bit index and an 89-entry step table. With these values, a run of full-scale alternating samples is enough to drive the index to its upper bound of 88 and to push the reconstruction into both saturation limits. A long run of silence then brings the index back down to 0. Gaps with the enable low and a reset in the middle of the stream check that state holds during gaps and that reset returns everything to zero, both at the 4-bit code pins.

// File: rtl/adpcm_enc_pkg.sv
package adpcm_enc_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int STEP_W    = 15;
  localparam int IDX_W     = 7;
  localparam int IDX_MAX   = 88;
  localparam int STEP_BASE = 7;
  localparam int STEP_CAP  = (1 << STEP_W) - 1;

  typedef logic signed [SAMPLE_W-1:0] sample_t;

  typedef struct packed {
    logic       sgn;
    logic [2:0] mag;
  } code_t;

  // Geometric step ladder: each entry grows by about ten percent.
  function automatic int step_at(input int k);
    int s;
    s = STEP_BASE;
    for (int i = 0; i < k; i++) begin
      s = s + s / 10 + 1;
      if (s > STEP_CAP) s = STEP_CAP;
    end
    return s;
  endfunction
endpackage

// File: rtl/mulaw_expand.sv
module mulaw_expand
  import adpcm_enc_pkg::*;
(
  input  logic [7:0] law_byte,
  output sample_t    lin
);
  logic [7:0]          u;
  logic [14:0]         biased;
  logic [14:0]         mag;

  always_comb begin
    u      = ~law_byte;
    biased = ({7'd0, u[3:0], 3'd0} + 15'd132) << u[6:4];
    mag    = biased - 15'd132;
    lin    = u[7] ? -sample_t'({1'b0, mag}) : sample_t'({1'b0, mag});
  end
endmodule

// File: rtl/step_rom.sv
module step_rom
  import adpcm_enc_pkg::*;
#(
  parameter int ENTRIES = IDX_MAX + 1,
  parameter int SW      = STEP_W,
  parameter int IW      = IDX_W
) (
  input  logic [IW-1:0] idx,
  output logic [SW-1:0] step
);
  logic [SW-1:0] lut [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_lut
    localparam int VAL = step_at(g);
    assign lut[g] = VAL[SW-1:0];
  end

  always_comb begin
    if (int'(idx) < ENTRIES) step = lut[idx];
    else                     step = lut[ENTRIES-1];
  end
endmodule

// File: rtl/adapt_quant.sv
module adapt_quant
  import adpcm_enc_pkg::*;
(
  input  sample_t           lin,
  input  sample_t           pred,
  input  logic [STEP_W-1:0] step,
  input  logic [IDX_W-1:0]  idx,
  output code_t             code,
  output sample_t           pred_nx,
  output logic [IDX_W-1:0]  idx_nx
);
  localparam int DW = SAMPLE_W + 1;

  logic signed [DW-1:0] diff;
  logic [DW-1:0]        dabs, rem, st, delta;
  logic signed [DW:0]   recon;
  logic signed [IDX_W:0] idx_s;
  logic [2:0]           mag;
  logic                 neg;

  always_comb begin
    diff  = {lin[SAMPLE_W-1], lin} - {pred[SAMPLE_W-1], pred};
    neg   = diff[DW-1];
    dabs  = neg ? DW'(-diff) : DW'(diff);
    st    = {{(DW-STEP_W){1'b0}}, step};
    mag   = 3'd0;
    rem   = dabs;
    delta = st >> 3;
    if (rem >= st) begin
      mag[2] = 1'b1;
      rem    = rem - st;
      delta  = delta + st;
    end
    if (rem >= (st >> 1)) begin
      mag[1] = 1'b1;
      rem    = rem - (st >> 1);
      delta  = delta + (st >> 1);
    end
    if (rem >= (st >> 2)) begin
      mag[0] = 1'b1;
      delta  = delta + (st >> 2);
    end
    code.sgn = neg;
    code.mag = mag;

    if (neg) recon = {{2{pred[SAMPLE_W-1]}}, pred} - {1'b0, delta};
    else     recon = {{2{pred[SAMPLE_W-1]}}, pred} + {1'b0, delta};
    if      (recon > 18'sd32767)  pred_nx = 16'sh7FFF;
    else if (recon < -18'sd32768) pred_nx = 16'sh8000;
    else                          pred_nx = recon[SAMPLE_W-1:0];

    idx_s = {1'b0, idx};
    case (mag)
      3'd4:    idx_s = idx_s + 8'sd2;
      3'd5:    idx_s = idx_s + 8'sd4;
      3'd6:    idx_s = idx_s + 8'sd6;
      3'd7:    idx_s = idx_s + 8'sd8;
      default: idx_s = idx_s - 8'sd1;
    endcase
    if (idx_s < 0)                    idx_nx = '0;
    else if (idx_s > IDX_MAX)         idx_nx = IDX_W'(IDX_MAX);
    else                              idx_nx = idx_s[IDX_W-1:0];
  end
endmodule

// File: rtl/adpcm_speech_enc.sv
module adpcm_speech_enc
  import adpcm_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_en,
  input  logic [7:0] law_byte,
  output logic [3:0] adpcm_code
);
  logic [1:0]        rst_sync;
  logic              rst_ok;
  sample_t           lin, pred_q, pred_d;
  logic [STEP_W-1:0] step;
  logic [IDX_W-1:0]  idx_q, idx_d;
  code_t             code_q, code_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  mulaw_expand u_expand (.law_byte(law_byte), .lin(lin));

  step_rom #(.ENTRIES(IDX_MAX + 1), .SW(STEP_W), .IW(IDX_W)) u_rom (
    .idx(idx_q), .step(step)
  );

  adapt_quant u_quant (
    .lin(lin), .pred(pred_q), .step(step), .idx(idx_q),
    .code(code_d), .pred_nx(pred_d), .idx_nx(idx_d)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      code_q <= '0;
      pred_q <= '0;
      idx_q  <= '0;
    end else if (enc_en) begin
      code_q <= code_d;
      pred_q <= pred_d;
      idx_q  <= idx_d;
    end
  end

  assign adpcm_code = code_q;

  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_ok)
    int'(idx_q) <= IDX_MAX);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !enc_en |=> ($stable(code_q) && $stable(pred_q) && $stable(idx_q)));

  a_r5_idx_move: assert property (@(posedge clk) disable iff (!rst_ok)
    enc_en |=> ((code_q.mag < 3'd4)
      ? ((int'(idx_q) + 1 == int'($past(idx_q))) || (idx_q == 0 && $past(idx_q) == 0))
      : ((idx_q > $past(idx_q)) || int'(idx_q) == IDX_MAX)));

  a_r4_pred_dir: assert property (@(posedge clk) disable iff (!rst_ok)
    enc_en |=> (code_q.sgn ? (pred_q <= $past(pred_q)) : (pred_q >= $past(pred_q))));

  a_r2_sign: assert property (@(posedge clk) disable iff (!rst_ok)
    enc_en |=> (code_q.sgn == ($past(lin) < $past(pred_q))));
endmodule

// File: tb/tb_adpcm_speech_enc.sv
`timescale 1ns/1ps
module tb_adpcm_speech_enc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enc_en;
  logic [7:0] law_byte;
  logic [3:0] adpcm_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0] q_exp[$];
  string      q_tag[$];

  int         m_pred, m_idx;
  logic [3:0] m_code;

  always #2 clk = ~clk;

  adpcm_speech_enc dut (
    .clk(clk), .rst_n(rst_n), .enc_en(enc_en),
    .law_byte(law_byte), .adpcm_code(adpcm_code)
  );

  function automatic int mu_lin(input logic [7:0] b);
    logic [7:0] u;
    int mag;
    u   = ~b;
    mag = (((int'(u[3:0]) * 8) + 132) << u[6:4]) - 132;
    return u[7] ? -mag : mag;
  endfunction

  function automatic int step_of(input int k);
    int s = 7;
    for (int i = 0; i < k; i++) begin
      s = s + s / 10 + 1;
      if (s > 32767) s = 32767;
    end
    return s;
  endfunction

  task automatic model_sample(input logic [7:0] b);
    int d, a, st, dl, p;
    logic [2:0] mg;
    st = step_of(m_idx);
    d  = mu_lin(b) - m_pred;
    a  = (d < 0) ? -d : d;
    mg = 3'd0;
    dl = st / 8;
    if (a >= st)     begin mg[2] = 1; a -= st;     dl += st;     end
    if (a >= st / 2) begin mg[1] = 1; a -= st / 2; dl += st / 2; end
    if (a >= st / 4) begin mg[0] = 1;              dl += st / 4; end
    p = (d < 0) ? m_pred - dl : m_pred + dl;
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    m_pred = p;
    case (mg)
      3'd4: m_idx += 2;
      3'd5: m_idx += 4;
      3'd6: m_idx += 6;
      3'd7: m_idx += 8;
      default: m_idx -= 1;
    endcase
    if (m_idx < 0)  m_idx = 0;
    if (m_idx > 88) m_idx = 88;
    m_code = {(d < 0), mg};
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s code=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies a sample away from the edge and queues its expected code.
  task automatic drive(input logic [7:0] b, input logic en, input string tag, input bit pre);
    @(negedge clk);
    law_byte = b;
    enc_en   = en;
    if (en) model_sample(b);
    q_exp.push_back(m_code);
    q_tag.push_back(tag);
    if (pre) begin
      #0.5;
      check("R7 before edge", adpcm_code, q_exp.size() > 1 ? q_exp[q_exp.size()-2] : prev_code);
    end
  endtask

  logic [3:0] prev_code;

  // Monitor: compares each result just after the edge that produced it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        prev_code = q_exp[0];
        check(q_tag.pop_front(), adpcm_code, q_exp.pop_front());
      end
    end
  end

  task automatic drain;
    @(posedge clk);
    #1.5;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n  = 1'b0;
    enc_en = 1'b0;
    m_pred = 0; m_idx = 0; m_code = 4'h0;
    prev_code = 4'h0;
    #1;
    check("R9 reset code", adpcm_code, 4'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 code after release", adpcm_code, 4'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; enc_en = 1'b0; law_byte = 8'hFF;
    m_pred = 0; m_idx = 0; m_code = 4'h0; prev_code = 4'h0;
    repeat (2) @(negedge clk);
    do_reset();

    // R9: first sample sees zero prediction and step 7
    drive(8'hFE, 1'b1, "R9 first sample", 1'b0);
    drain();
    check("R9 first code is 0x5", adpcm_code, 4'h5);

    // R2: silence below a positive prediction gives a negative sign
    drive(8'hFF, 1'b1, "R2 zero input", 1'b0);
    // R1/R3: sweep over all segments and both signs
    for (int i = 0; i < 64; i++) drive(8'(i * 4 + 1), 1'b1, "R1 R3 sweep", (i % 8) == 0);
    for (int i = 0; i < 32; i++) drive(8'(8'h80 + i * 3), 1'b1, "R1 R3 positive ramp", 1'b0);

    // R4/R5/R6: full-scale alternation drives step to top and saturates
    for (int i = 0; i < 40; i++) drive((i % 2) ? 8'h00 : 8'h80, 1'b1, "R4 R6 full scale", 1'b0);
    for (int i = 0; i < 6; i++)  drive(8'h80, 1'b1, "R4 saturate high", 1'b0);
    for (int i = 0; i < 6; i++)  drive(8'h00, 1'b1, "R4 saturate low", 1'b0);

    // R5: long silence walks the index down to 0
    for (int i = 0; i < 120; i++) drive(8'hFF, 1'b1, "R5 index decay", 1'b0);
    drive(8'hFE, 1'b1, "R5 R6 small step after decay", 1'b0);

    // R8: enable low holds code and state while input changes
    drive(8'h85, 1'b1, "R8 before gap", 1'b0);
    for (int i = 0; i < 10; i++) drive(8'(i * 23), 1'b0, "R8 gap hold", 1'b0);
    drive(8'h3A, 1'b1, "R8 resume", 1'b0);
    for (int i = 0; i < 20; i++) drive(8'(8'hC0 - i * 5), (i % 3) != 1, "R8 R7 sparse enable", (i % 4) == 0);
    drain();

    // R9: reset in mid-stream returns to the initial state
    do_reset();
    drive(8'hFE, 1'b1, "R9 after mid reset", 1'b0);
    drive(8'h70, 1'b1, "R2 negative input", 1'b0);
    drain();
    drain();
    finish_run();
  end
endmodule